// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block forms the byte a host sees on the read data path of a flash array controller. An embedded program or erase operation may be running. While it runs, each read returns a status byte instead of array contents, so the host can poll for completion. Bit 7 carries a polarity flag. During a program it is the inverse of the top bit of the byte being written, and during an erase it is 0. Bit 6 alternates on every completed read. Bit 5 reports that the operation ran past its time limit. Bit 3 reports that the sector-erase acceptance window is still open. The remaining bits read 0.

When the operation is not busy, the block passes the array read data straight through. This also returns the true written value of bit 7 once a program completes. The alternating bit is held in a single flop. It advances on the falling edge of the read strobe, only while an operation is busy, and it restarts at 0 whenever a new operation begins. The output can be registered (the default) or combinational, chosen by a parameter.

Top module: `opstat_reporter`

## Requirements
- R1: While reset is asserted, rd_data is all zeros, and the alternating bit starts at 0 after reset.
- R2: While op_busy is 0, rd_data equals array_data. This includes bit 7, which then shows the true stored value.
- R3: While op_busy is 1 and op_kind is 2'b00 (program), rd_data bit 7 equals the inverse of prog_d7.
- R4: While op_busy is 1 and op_kind is 2'b01 (chip erase), 2'b10 (sector erase) or 2'b11 (treated as erase), rd_data bit 7 is 0.
- R5: While op_busy is 1, rd_data bit 6 inverts once for each falling edge of rd_strobe.
- R6: Raising rd_strobe, or holding it high, does not change rd_data bit 6. Only the falling edge advances it.
- R7: When op_busy rises, rd_data bit 6 reads 0 from the first status byte of the new operation, whatever value it held before.
- R8: While op_busy is 1, rd_data bit 5 equals op_timeout.
- R9: While op_busy is 1, rd_data bit 3 equals erase_window_open when op_kind is 2'b10, and is 0 for any other op_kind.
- R10: While op_busy is 1, rd_data bits 4, 2, 1, 0 and every bit above bit 7 read 0.
- R11: With the default registered output, rd_data reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_busy | input | 1 | Embedded operation in progress |
| op_kind | input | 2 | Operation kind: 00 program, 01 chip erase, 10 sector erase, 11 erase |
| prog_d7 | input | 1 | Latched bit 7 of the byte being programmed |
| op_timeout | input | 1 | Operation exceeded its time limit |
| erase_window_open | input | 1 | Sector-erase acceptance window still open |
| rd_strobe | input | 1 | Host read strobe, synchronous to clk |
| array_data | input | DATA_W | Array read data |
| rd_data | output | DATA_W | Read data returned to the host |

## Verification
Every static field (bits 7, 5 and 3, the zero bits and the idle pass-through) is due one rising edge after the inputs change. Each table vector is therefore driven on a falling edge and sampled on the next falling edge, and one directed check confirms that the old value is still present just before that edge. The alternating bit is due two rising edges after rd_strobe falls: one edge to detect the fall and one to register the output. The read task drops the strobe and then waits two falling edges before it samples. A new operation clears the alternating bit in the same edge that registers the first status byte, so that check samples one edge after op_busy rises.

// File: rtl/opstat_pkg.sv
package opstat_pkg;

   typedef enum logic [1:0] {
      OPK_PROGRAM      = 2'b00,
      OPK_CHIP_ERASE   = 2'b01,
      OPK_SECTOR_ERASE = 2'b10,
      OPK_ERASE_OTHER  = 2'b11
   } opk_e;

   localparam int unsigned STAT_W      = 8;
   localparam int unsigned POLL_BIT    = 7;
   localparam int unsigned TOGGLE_BIT  = 6;
   localparam int unsigned TIMEOUT_BIT = 5;
   localparam int unsigned WINDOW_BIT  = 3;

endpackage

// File: rtl/opstat_toggle.sv
module opstat_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic op_busy,
   input  logic rd_strobe,
   output logic op_start,
   output logic tog_eff,
   output logic tog_q
);

   logic strobe_q;
   logic busy_q;
   logic strobe_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         busy_q   <= 1'b0;
      end else begin
         strobe_q <= rd_strobe;
         busy_q   <= op_busy;
      end
   end

   assign strobe_fall = strobe_q & ~rd_strobe;
   assign op_start    = op_busy & ~busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tog_q <= 1'b0;
      else if (op_start)
         tog_q <= 1'b0;
      else if (strobe_fall && op_busy)
         tog_q <= ~tog_q;
   end

   // a new operation presents 0 in the same cycle it is detected
   assign tog_eff = op_start ? 1'b0 : tog_q;

   assert_toggle_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(op_busy) |=> (tog_q == 1'b0));

   assert_toggle_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_busy && $past(rd_strobe) && !rd_strobe && $past(op_busy)) |=> (tog_q != $past(tog_q)));

   assert_toggle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe || !op_busy) |=> $stable(tog_q) || $rose(op_busy));

endmodule

// File: rtl/opstat_compose.sv
module opstat_compose
   import opstat_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              op_busy,
   input  logic [1:0]        op_kind,
   input  logic              prog_d7,
   input  logic              op_timeout,
   input  logic              erase_window_open,
   input  logic              tog,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] status
);

   logic is_program;
   logic is_sector;

   assign is_program = (opk_e'(op_kind) == OPK_PROGRAM);
   assign is_sector  = (opk_e'(op_kind) == OPK_SECTOR_ERASE);

   always_comb begin
      status = '0;
      if (op_busy) begin
         status[POLL_BIT]    = is_program ? ~prog_d7 : 1'b0;
         status[TOGGLE_BIT]  = tog;
         status[TIMEOUT_BIT] = op_timeout;
         status[WINDOW_BIT]  = is_sector & erase_window_open;
      end else begin
         status = array_data;
      end
   end

endmodule

// File: rtl/opstat_reporter.sv
module opstat_reporter
   import opstat_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_busy,
   input  logic [1:0]        op_kind,
   input  logic              prog_d7,
   input  logic              op_timeout,
   input  logic              erase_window_open,
   input  logic              rd_strobe,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_data
);

   localparam logic [DATA_W-1:0] SPARE_MASK =
      ~((DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOGGLE_BIT) |
        (DATA_W'(1) << TIMEOUT_BIT) | (DATA_W'(1) << WINDOW_BIT));

   initial begin
      assert_width_ok: assert (DATA_W >= STAT_W)
         else $error("DATA_W must hold the status byte");
   end

   logic              op_start;
   logic              tog_eff;
   logic              tog_q;
   logic [DATA_W-1:0] status;

   opstat_toggle tog_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_busy   (op_busy),
      .rd_strobe (rd_strobe),
      .op_start  (op_start),
      .tog_eff   (tog_eff),
      .tog_q     (tog_q)
   );

   opstat_compose #(.DATA_W(DATA_W)) comp_i (
      .op_busy           (op_busy),
      .op_kind           (op_kind),
      .prog_d7           (prog_d7),
      .op_timeout        (op_timeout),
      .erase_window_open (erase_window_open),
      .tog               (tog_eff),
      .array_data        (array_data),
      .status            (status)
   );

   generate
      if (REG_OUT) begin : g_reg_out
         logic [DATA_W-1:0] out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= status;
         end
         assign rd_data = out_q;

         assert_idle_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(op_busy)) |-> (rd_data == $past(array_data)));

         assert_prog_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_busy) && ($past(op_kind) == 2'b00))
               |-> (rd_data[POLL_BIT] == ~$past(prog_d7)));

         assert_erase_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_busy) && ($past(op_kind) != 2'b00))
               |-> (rd_data[POLL_BIT] == 1'b0));

         assert_timeout_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_busy)) |-> (rd_data[TIMEOUT_BIT] == $past(op_timeout)));

         assert_spare_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_busy)) |-> ((rd_data & SPARE_MASK) == '0));
      end else begin : g_comb_out
         assign rd_data = status;

         assert_spare_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
            op_busy |-> ((rd_data & SPARE_MASK) == '0));
      end
   endgenerate

endmodule

// File: tb/opstat_reporter_tb.sv
module opstat_reporter_tb_top;

   localparam int unsigned DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_busy = 1'b0;
   logic [1:0]    op_kind = 2'b00;
   logic          prog_d7 = 1'b0;
   logic          op_timeout = 1'b0;
   logic          erase_window_open = 1'b0;
   logic          rd_strobe = 1'b0;
   logic [DW-1:0] array_data = '0;
   logic [DW-1:0] rd_data;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   opstat_reporter #(.DATA_W(DW), .REG_OUT(1'b1)) dut_i (
      .clk               (clk),
      .rst_n             (rst_n),
      .op_busy           (op_busy),
      .op_kind           (op_kind),
      .prog_d7           (prog_d7),
      .op_timeout        (op_timeout),
      .erase_window_open (erase_window_open),
      .rd_strobe         (rd_strobe),
      .array_data        (array_data),
      .rd_data           (rd_data)
   );

   // vector: {busy, kind[1:0], d7, timeout, window, array[7:0], expected[7:0]}
   localparam int NVEC = 11;
   localparam logic [21:0] VEC [NVEC] = '{
      {1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5},  // R2 idle pass
      {1'b0, 2'b10, 1'b1, 1'b1, 1'b1, 8'h3C, 8'h3C},  // R2 status inputs ignored
      {1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h00},  // R3 R10 inverted d7
      {1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h80},  // R3
      {1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 8'h00, 8'hA0},  // R8
      {1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00},  // R9 window masked on program
      {1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 8'h55, 8'h00},  // R4 R9 chip erase
      {1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h08},  // R4 R9 sector window
      {1'b1, 2'b10, 1'b1, 1'b1, 1'b1, 8'h00, 8'h28},  // R8 R9
      {1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h00},  // R4 reserved kind
      {1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 8'h80, 8'h80}   // R2 true bit 7
   };

   task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: rd_data actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic do_read();
      @(negedge clk) rd_strobe = 1'b1;
      @(negedge clk) rd_strobe = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check("R1 reset value", rd_data, 8'h00);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         {op_busy, op_kind, prog_d7, op_timeout, erase_window_open, array_data} = VEC[i][21:8];
         @(negedge clk);
         check($sformatf("vector %0d (R2..R10)", i), rd_data, VEC[i][7:0]);
      end

      // R11 latency: old value held until the next rising edge
      @(negedge clk) array_data = 8'h11;
      @(negedge clk);
      array_data = 8'h22;
      #1 check("R11 before edge", rd_data, 8'h11);
      @(negedge clk);
      check("R11 after edge", rd_data, 8'h22);

      // R1: alternating bit starts at 0 after reset; program with d7=1
      @(negedge clk);
      op_busy = 1'b1; op_kind = 2'b00; prog_d7 = 1'b1; op_timeout = 1'b0;
      erase_window_open = 1'b0;
      @(negedge clk);
      check("R1 R7 first status", rd_data, 8'h00);

      // R5: successive reads alternate bit 6
      do_read();
      check("R5 read 1", rd_data, 8'h40);
      do_read();
      check("R5 read 2", rd_data, 8'h00);
      do_read();
      check("R5 read 3", rd_data, 8'h40);

      // R6: strobe held high does not advance
      @(negedge clk) rd_strobe = 1'b1;
      repeat (4) @(negedge clk);
      check("R6 strobe held high", rd_data, 8'h40);
      rd_strobe = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R5 R6 flip on fall", rd_data, 8'h00);
      do_read();
      check("R5 back to 1", rd_data, 8'h40);

      // completion: array data returns, strobes while idle
      op_busy = 1'b0; array_data = 8'hC3;
      @(negedge clk);
      check("R2 done", rd_data, 8'hC3);
      do_read();
      check("R2 idle read", rd_data, 8'hC3);

      // R7: new sector erase starts with bit 6 at 0
      op_busy = 1'b1; op_kind = 2'b10; erase_window_open = 1'b1;
      @(negedge clk);
      check("R7 restart at 0", rd_data, 8'h08);
      do_read();
      check("R5 R9 toggle in window", rd_data, 8'h48);
      erase_window_open = 1'b0;
      @(negedge clk);
      check("R9 window closed", rd_data, 8'h40);

      // R1: reset mid-operation clears output
      rst_n = 1'b0;
      #1 check("R1 async reset", rd_data, 8'h00);
      @(negedge clk) rst_n = 1'b1;
      op_busy = 1'b0; array_data = 8'h5A;
      @(negedge clk);
      check("R2 after reset", rd_data, 8'h5A);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule